// File: doc/BRIEF.md
# RS-485 Driver Enable Controller with 8N1 Transmitter

This block pairs a small 8N1 UART transmitter with a controller that drives the output-enable pin of an RS-485 line driver. The controller watches the transmitter's own frame events: a pulse when a character's start bit is launched, a pulse when a stop bit completes, and whether a frame is still being shifted. From these it keeps the line driver switched on for exactly as long as the bus must be held. The transmitter has a one-deep holding register. A character written while another is on the wire goes out immediately after that character's stop bit, with no idle bits in between.

Three configuration inputs shape the pin. The first decides whether transmit activity drives the pin at all. The second picks the pin's active level. The third, the turnaround hold, keeps the driver enabled for one extra character time (ten bit periods) after the last stop bit, so that slow bus turnaround does not cut off the final stop bit. The enable is taken from a register and never drops between characters that follow each other, whether the next character starts right at the stop bit or during the turnaround hold. Configuration is sampled only while the line is idle. A write during a transmission therefore waits until the current burst, including any hold, has ended.

Top module: `rs485_de_uart`

## Requirements
- R1: While reset is high and in the first cycle after it, the serial output is 1, the holding register reports ready, and the enable pin sits at its inactive level (0 with the reset polarity of active high).
- R2: Every character is framed as one start bit of 0, then eight data bits least significant first, then one stop bit of 1. Each bit lasts CLKS_PER_BIT clock cycles.
- R3: Ready is low while the holding register is full. A character waiting there begins its start bit in the same cycle that the previous stop bit ends, with zero idle bits.
- R4: The enable pin turns active in the same clock cycle in which the serial output enters a start bit.
- R5: With the turnaround hold off, the enable pin turns inactive in the same cycle that the last stop bit ends. A single character keeps it active for exactly 10×CLKS_PER_BIT cycles.
- R6: With the turnaround hold on, the enable pin stays active for exactly 10 further bit periods after the last stop bit. A single character keeps it active for 20×CLKS_PER_BIT cycles.
- R7: The enable pin never leaves its active level between characters of one burst. This holds both for characters sent back to back and for a character that starts during the turnaround hold.
- R8: Polarity input 1 makes the active level 1 (inactive 0). Polarity input 0 makes the active level 0 (inactive 1).
- R9: With the enable-function input at 0, the pin rests at the inactive level of the selected polarity and does not change with transmit activity.
- R10: Changes to the three configuration inputs take effect only when the transmitter is idle and the enable is inactive. A change during a frame or a hold does not alter that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| cfg_en_i | input | 1 | 1: transmit activity drives the enable pin |
| cfg_pol_i | input | 1 | Active level of the enable pin |
| cfg_hold_i | input | 1 | 1: hold the enable one character time after the last stop bit |
| tx_data_i | input | DATA_W | Character to send |
| tx_valid_i | input | 1 | Offer tx_data_i to the holding register |
| tx_ready_o | output | 1 | Holding register is empty and accepts a character |
| txd_o | output | 1 | Serial data line |
| de_o | output | 1 | Line driver enable pin |

## Verification
The main target is the seam between characters. In that cycle the stop-bit event and the start-bit event arrive together. A controller that handles the stop first shows a one-cycle pulse on the pin there, and the bench counts the pin's falling edges over a whole burst to catch it. The bench measures the exact number of active cycles for a lone character with and without the turnaround hold. An off-by-one tick counter, or a hold that ignores a new start, changes that count. It also changes polarity and hold in the middle of a frame: a design that samples configuration at once would flip the pin or shorten the hold partway through the burst.

// File: rtl/rs485de_pkg.sv
package rs485de_pkg;

    typedef enum logic {
        TX_IDLE  = 1'b0,
        TX_SHIFT = 1'b1
    } tx_state_e;

    typedef struct packed {
        logic en;
        logic pol;
        logic hold;
    } de_cfg_t;

    localparam de_cfg_t CFG_RESET = '{en: 1'b0, pol: 1'b1, hold: 1'b0};

endpackage

// File: rtl/rs485de_baud.sv
module rs485de_baud #(
    parameter int CLKS_PER_BIT = 16
) (
    input  logic clk_i,
    input  logic rst_i,
    output logic tick_o
);
    localparam int CW = (CLKS_PER_BIT > 2) ? $clog2(CLKS_PER_BIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLKS_PER_BIT - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = (cnt_q == LAST);
        cnt_d  = tick_o ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) cnt_q <= '0;
        else       cnt_q <= cnt_d;
    end
endmodule

// File: rtl/rs485de_tx.sv
module rs485de_tx
    import rs485de_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              tick_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              valid_i,
    output logic              ready_o,
    output logic              txd_o,
    output logic              busy_o,
    output logic              start_o,
    output logic              stop_o
);
    localparam int FRAME_W = DATA_W + 2;
    localparam int IDX_W   = $clog2(FRAME_W);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_W - 1);

    typedef struct packed {
        tx_state_e          state;
        logic               full;
        logic [DATA_W-1:0]  hold;
        logic [FRAME_W-1:0] frame;
        logic [IDX_W-1:0]   idx;
        logic               txd;
    } tx_reg_t;

    tx_reg_t r_q, r_d;
    logic    accept;

    always_comb begin
        r_d     = r_q;
        start_o = 1'b0;
        stop_o  = 1'b0;
        accept  = valid_i && !r_q.full;

        if (tick_i) begin
            case (r_q.state)
                TX_IDLE: begin
                    if (r_q.full) start_o = 1'b1;
                end
                TX_SHIFT: begin
                    if (r_q.idx == LAST_IDX) begin
                        stop_o = 1'b1;
                        if (r_q.full) begin
                            start_o = 1'b1;
                        end else begin
                            r_d.state = TX_IDLE;
                            r_d.txd   = 1'b1;
                        end
                    end else begin
                        r_d.idx   = r_q.idx + 1'b1;
                        r_d.frame = {1'b1, r_q.frame[FRAME_W-1:1]};
                        r_d.txd   = r_q.frame[1];
                    end
                end
                default: r_d.state = TX_IDLE;
            endcase
        end

        // Start bit is launched in the very tick that frees the shifter.
        if (start_o) begin
            r_d.state = TX_SHIFT;
            r_d.frame = {1'b1, r_q.hold, 1'b0};
            r_d.idx   = '0;
            r_d.txd   = 1'b0;
            r_d.full  = 1'b0;
        end

        if (accept) begin
            r_d.full = 1'b1;
            r_d.hold = data_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            r_q.state <= TX_IDLE;
            r_q.full  <= 1'b0;
            r_q.hold  <= '0;
            r_q.frame <= '1;
            r_q.idx   <= '0;
            r_q.txd   <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign ready_o = !r_q.full;
    assign txd_o   = r_q.txd;
    assign busy_o  = (r_q.state == TX_SHIFT);
endmodule

// File: rtl/rs485de_ctrl.sv
module rs485de_ctrl
    import rs485de_pkg::*;
#(
    parameter int CHAR_BITS = 10
) (
    input  logic    clk_i,
    input  logic    rst_i,
    input  logic    tick_i,
    input  logic    busy_i,
    input  logic    start_i,
    input  logic    stop_i,
    input  de_cfg_t cfg_i,
    output logic    de_o,
    output logic    act_o,
    output de_cfg_t cfg_o
);
    localparam int CW = $clog2(CHAR_BITS + 1);
    localparam logic [CW-1:0] HOLD_BITS = CW'(CHAR_BITS);

    typedef struct packed {
        de_cfg_t         cfg;
        logic            act;
        logic [CW-1:0]   cnt;
        logic            de;
    } ctrl_reg_t;

    ctrl_reg_t r_q, r_d;
    logic      line_idle;

    always_comb begin
        r_d       = r_q;
        line_idle = !busy_i && !r_q.act && !start_i;

        if (line_idle) r_d.cfg = cfg_i;

        // A start in the same cycle as a stop wins, so the pin never dips.
        if (start_i) begin
            r_d.act = 1'b1;
            r_d.cnt = '0;
        end else if (stop_i) begin
            if (r_q.cfg.hold) r_d.cnt = HOLD_BITS;
            else              r_d.act = 1'b0;
        end else if (tick_i && (r_q.cnt != '0)) begin
            r_d.cnt = r_q.cnt - 1'b1;
            if (r_q.cnt == CW'(1)) r_d.act = 1'b0;
        end

        r_d.de = (r_d.cfg.en && r_d.act) ? r_d.cfg.pol : !r_d.cfg.pol;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            r_q.cfg <= CFG_RESET;
            r_q.act <= 1'b0;
            r_q.cnt <= '0;
            r_q.de  <= !CFG_RESET.pol;
        end else begin
            r_q <= r_d;
        end
    end

    assign de_o  = r_q.de;
    assign act_o = r_q.act;
    assign cfg_o = r_q.cfg;
endmodule

// File: rtl/rs485_de_uart.sv
module rs485_de_uart
    import rs485de_pkg::*;
#(
    parameter int CLKS_PER_BIT = 16,
    parameter int DATA_W       = 8
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              cfg_en_i,
    input  logic              cfg_pol_i,
    input  logic              cfg_hold_i,
    input  logic [DATA_W-1:0] tx_data_i,
    input  logic              tx_valid_i,
    output logic              tx_ready_o,
    output logic              txd_o,
    output logic              de_o
);
    localparam int CHAR_BITS = DATA_W + 2;

    logic    baud_tick;
    logic    tx_busy;
    logic    frame_start;
    logic    frame_stop;
    logic    de_act;
    de_cfg_t cfg_req;
    de_cfg_t eff_cfg;
    logic    cfg_en_q;
    logic    cfg_pol_q;
    logic    cfg_hold_q;

    assign cfg_req    = '{en: cfg_en_i, pol: cfg_pol_i, hold: cfg_hold_i};
    assign cfg_en_q   = eff_cfg.en;
    assign cfg_pol_q  = eff_cfg.pol;
    assign cfg_hold_q = eff_cfg.hold;

    rs485de_baud #(.CLKS_PER_BIT(CLKS_PER_BIT)) baud_i (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .tick_o (baud_tick)
    );

    rs485de_tx #(.DATA_W(DATA_W)) tx_i (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .tick_i  (baud_tick),
        .data_i  (tx_data_i),
        .valid_i (tx_valid_i),
        .ready_o (tx_ready_o),
        .txd_o   (txd_o),
        .busy_o  (tx_busy),
        .start_o (frame_start),
        .stop_o  (frame_stop)
    );

    rs485de_ctrl #(.CHAR_BITS(CHAR_BITS)) ctrl_i (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .tick_i  (baud_tick),
        .busy_i  (tx_busy),
        .start_i (frame_start),
        .stop_i  (frame_stop),
        .cfg_i   (cfg_req),
        .de_o    (de_o),
        .act_o   (de_act),
        .cfg_o   (eff_cfg)
    );
endmodule

// File: rtl/rs485de_chk.sv
module rs485de_chk (
    input logic clk_i,
    input logic rst_i,
    input logic txd_o,
    input logic de_o,
    input logic tx_ready_o,
    input logic tx_busy,
    input logic frame_start,
    input logic frame_stop,
    input logic de_act,
    input logic cfg_en_q,
    input logic cfg_pol_q,
    input logic cfg_hold_q
);
    AST_RESET_IDLE: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> (txd_o && tx_ready_o && !de_act)); // R1
    AST_START_BIT_LOW: assert property (@(posedge clk_i) disable iff (rst_i)
        frame_start |=> !txd_o); // R2
    AST_HOLDREG_KEEPS_FULL: assert property (@(posedge clk_i) disable iff (rst_i)
        (!tx_ready_o && !frame_start) |=> !tx_ready_o); // R3
    AST_START_ENABLES: assert property (@(posedge clk_i) disable iff (rst_i)
        frame_start |=> de_act); // R4
    AST_DROP_AT_STOP: assert property (@(posedge clk_i) disable iff (rst_i)
        (frame_stop && !frame_start && !cfg_hold_q) |=> !de_act); // R5
    AST_HOLD_AFTER_STOP: assert property (@(posedge clk_i) disable iff (rst_i)
        (frame_stop && !frame_start && cfg_hold_q) |=> de_act); // R6
    AST_FRAME_KEEPS_ENABLE: assert property (@(posedge clk_i) disable iff (rst_i)
        (tx_busy && !frame_stop) |=> de_act); // R7
    AST_SEAM_NO_GAP: assert property (@(posedge clk_i) disable iff (rst_i)
        (frame_stop && frame_start) |=> (de_act && tx_busy)); // R7
    AST_ACTIVE_LEVEL: assert property (@(posedge clk_i) disable iff (rst_i)
        (cfg_en_q && de_act) |-> (de_o == cfg_pol_q)); // R8
    AST_DISABLED_PIN: assert property (@(posedge clk_i) disable iff (rst_i)
        !cfg_en_q |-> (de_o == !cfg_pol_q)); // R9
    AST_CFG_FROZEN: assert property (@(posedge clk_i) disable iff (rst_i)
        (tx_busy || de_act) |=> $stable({cfg_en_q, cfg_pol_q, cfg_hold_q})); // R10
endmodule

bind rs485_de_uart rs485de_chk chk_i (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .txd_o       (txd_o),
    .de_o        (de_o),
    .tx_ready_o  (tx_ready_o),
    .tx_busy     (tx_busy),
    .frame_start (frame_start),
    .frame_stop  (frame_stop),
    .de_act      (de_act),
    .cfg_en_q    (cfg_en_q),
    .cfg_pol_q   (cfg_pol_q),
    .cfg_hold_q  (cfg_hold_q)
);

// File: tb/rs485_de_uart_tb_top.sv
module rs485_de_uart_tb_top;
    localparam int CPB = 4;
    localparam int CHAR_CYC = 10 * CPB;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_en = 1'b1;
    logic       cfg_pol = 1'b1;
    logic       cfg_hold = 1'b0;
    logic [7:0] tx_data = '0;
    logic       tx_valid = 1'b0;
    logic       tx_ready;
    logic       txd;
    logic       de;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    always #5 clk = ~clk;

    rs485_de_uart #(.CLKS_PER_BIT(CPB), .DATA_W(8)) dut_i (
        .clk_i      (clk),
        .rst_i      (rst),
        .cfg_en_i   (cfg_en),
        .cfg_pol_i  (cfg_pol),
        .cfg_hold_i (cfg_hold),
        .tx_data_i  (tx_data),
        .tx_valid_i (tx_valid),
        .tx_ready_o (tx_ready),
        .txd_o      (txd),
        .de_o       (de)
    );

    // Behavioural reference model
    int         m_bcnt, m_pos, m_cnt;
    logic [7:0] m_q[$];
    logic [7:0] m_cur;
    logic       m_txd, m_act, m_de, m_en, m_pol, m_hold;
    logic       m_tick, m_acc, m_start, m_stop, m_was_idle;

    always @(posedge clk) begin
        if (rst) begin
            m_bcnt = 0; m_q.delete(); m_pos = -1; m_cnt = 0; m_cur = '0;
            m_txd = 1; m_act = 0; m_en = 0; m_pol = 1; m_hold = 0; m_de = 0;
        end else begin
            m_tick = (m_bcnt == CPB - 1);
            m_bcnt = m_tick ? 0 : m_bcnt + 1;
            m_acc = tx_valid && (m_q.size() == 0);
            m_start = 0; m_stop = 0;
            m_was_idle = (m_pos < 0);
            if (m_tick) begin
                if (m_pos < 0) begin
                    if (m_q.size() > 0) m_start = 1;
                end else if (m_pos == 9) begin
                    m_stop = 1;
                    if (m_q.size() > 0) m_start = 1;
                    else m_pos = -1;
                end else begin
                    m_pos++;
                end
            end
            if (m_start) begin m_cur = m_q.pop_front(); m_pos = 0; end
            if (m_acc) m_q.push_back(tx_data);
            if (m_pos < 0)       m_txd = 1;
            else if (m_pos == 0) m_txd = 0;
            else if (m_pos == 9) m_txd = 1;
            else                 m_txd = m_cur[m_pos-1];
            if (m_was_idle && !m_act && !m_start) begin
                m_en = cfg_en; m_pol = cfg_pol; m_hold = cfg_hold;
            end
            if (m_start) begin m_act = 1; m_cnt = 0; end
            else if (m_stop) begin
                if (m_hold) m_cnt = 10; else m_act = 0;
            end else if (m_tick && m_cnt > 0) begin
                m_cnt--;
                if (m_cnt == 0) m_act = 0;
            end
            m_de = (m_en && m_act) ? m_pol : !m_pol;
        end
    end

    // Per-cycle comparison plus pin activity monitors
    logic act_lvl = 1'b1;
    logic prev_de = 1'b0;
    int   act_cyc = 0, de_rise = 0, de_fall = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (!rst) begin
            check(txd == m_txd, "R2 txd vs model", txd, m_txd);
            check(tx_ready == (m_q.size() == 0), "R3 ready vs model", tx_ready, m_q.size() == 0);
            check(de == m_de, "R7 de vs model", de, m_de);
            if (de == act_lvl) act_cyc++;
            if (de && !prev_de) de_rise++;
            if (!de && prev_de) de_fall++;
        end
        prev_de = de;
        if (cycles > 100000 && !done) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 100000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic clr_mon(input logic lvl);
        act_lvl = lvl; act_cyc = 0; de_rise = 0; de_fall = 0;
    endtask

    task automatic send(input logic [7:0] b);
        while (!tx_ready) @(negedge clk);
        tx_data = b; tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!(tx_ready && m_pos < 0 && !m_act) && n < 5000);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(de == 1'b0, "R1 de in reset", de, 0);
        check(txd == 1'b1, "R1 txd in reset", txd, 1);
        rst = 1'b0;
        @(negedge clk);
        check(tx_ready == 1'b1, "R1 ready after reset", tx_ready, 1);
        check(de == 1'b0, "R1 de after reset", de, 0);
        repeat (4) @(negedge clk);

        // Single character, no hold: R4 / R5 / R2
        clr_mon(1'b1);
        send(8'hA5);
        while (txd) @(negedge clk);
        check(de == 1'b1, "R4 de active with start bit", de, 1);
        repeat (CPB) @(negedge clk);
        check(txd == 1'b1, "R2 first data bit (lsb of A5)", txd, 1);
        wait_idle();
        check(act_cyc == CHAR_CYC, "R5 active cycles, hold off", act_cyc, CHAR_CYC);
        check(de_fall == 1, "R5 single release", de_fall, 1);

        // Single character with turnaround hold: R6
        cfg_hold = 1'b1;
        repeat (2) @(negedge clk);
        clr_mon(1'b1);
        send(8'h3C);
        wait_idle();
        check(act_cyc == 2 * CHAR_CYC, "R6 active cycles, hold on", act_cyc, 2 * CHAR_CYC);

        // Burst of four back to back, hold off: R3 / R7
        cfg_hold = 1'b0;
        repeat (2) @(negedge clk);
        clr_mon(1'b1);
        for (int i = 0; i < 4; i++) send(8'(8'h11 * (i + 1)));
        wait_idle();
        check(act_cyc == 4 * CHAR_CYC, "R3 burst has no idle bits", act_cyc, 4 * CHAR_CYC);
        check(de_fall == 1, "R7 no dip inside burst", de_fall, 1);
        check(de_rise == 1, "R7 single assertion for burst", de_rise, 1);

        // Character started during turnaround hold: R7
        cfg_hold = 1'b1;
        repeat (2) @(negedge clk);
        clr_mon(1'b1);
        send(8'h00);
        repeat (CHAR_CYC + 3 * CPB) @(negedge clk);
        check(de == 1'b1, "R6 still held after stop", de, 1);
        send(8'hFF);
        wait_idle();
        check(de_fall == 1, "R7 no dip when restarting in hold", de_fall, 1);

        // Active-low polarity: R8
        cfg_hold = 1'b0; cfg_pol = 1'b0;
        repeat (3) @(negedge clk);
        check(de == 1'b1, "R8 idle level with active-low", de, 1);
        clr_mon(1'b0);
        send(8'h5A);
        while (txd) @(negedge clk);
        check(de == 1'b0, "R8 active-low during frame", de, 0);
        wait_idle();
        check(act_cyc == CHAR_CYC, "R8 active-low duration", act_cyc, CHAR_CYC);

        // Function disabled: R9
        cfg_en = 1'b0; cfg_pol = 1'b1;
        repeat (3) @(negedge clk);
        clr_mon(1'b1);
        send(8'h81); send(8'h7E);
        wait_idle();
        check(de_rise + de_fall == 0, "R9 pin untouched by traffic", de_rise + de_fall, 0);
        check(de == 1'b0, "R9 rests at inactive level", de, 0);

        // Configuration change mid-frame: R10
        cfg_en = 1'b1; cfg_pol = 1'b1; cfg_hold = 1'b0;
        repeat (3) @(negedge clk);
        clr_mon(1'b1);
        send(8'hC3);
        while (txd) @(negedge clk);
        repeat (3 * CPB) @(negedge clk);
        cfg_hold = 1'b1; cfg_pol = 1'b0;
        @(negedge clk);
        check(de == 1'b1, "R10 polarity not applied mid-frame", de, 1);
        while (de) @(negedge clk);
        check(act_cyc == CHAR_CYC, "R10 hold change ignored in frame", act_cyc, CHAR_CYC);
        repeat (3) @(negedge clk);
        check(de == 1'b1, "R10 new polarity applied when idle", de, 1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule